// File: doc/BRIEF.md
# Operand Source Resolver for Clause Constants and PC-Relative Immediates

This block turns the 8-bit operand-source index of a shader instruction into a description of the operand it names. The index can point at a uniform word, at one of six 64-bit constants embedded in the current clause, or at a fixed special value such as the lane or core number. For an embedded constant the block returns the requested 32-bit half. When the constant carries a PC-relative modifier, it also returns the sign-extended byte offset and the index of the clause that the offset reaches.

The index's low nibble is ORed into the selected constant. The slot comes from a fixed, non-linear map of the index's high nibble. A second, independent path decodes the two 4-bit modifier fields of a clause into the modifier codes of a constant pair. Uniform storage and special registers live elsewhere: for them the block only reports the kind, a selector and the word half.

All results are registered once, so a value applied before a rising clock edge appears on the outputs after that edge.

Top module: `fau_operand_resolver`

## Requirements
- R1: All outputs are registered and reflect the inputs present at the previous rising clock edge. While rst_ni is low, every output is zero.
- R2: When index bit 7 is set, kind_o is 0 (uniform), sel_o is index[6:0] and word_hi_o is the half-select flag. No error is raised.
- R3: An index from 0x20 to 0x7F gives kind_o = 1 (constant). Its high nibble picks the slot: 2→4, 3→5, 4→0, 5→1, 6→2, 7→3, reported on sel_o. The index's low nibble is ORed into bits [3:0] of the constant. With modifier 0 (none), operand_o is bits [63:32] of the result when the half-select flag is 1 and bits [31:0] when it is 0, and is_pc_o is 0.
- R4: An index below 0x20 gives kind_o = 2 (special) and sel_o = index. Index 7 and indices 16 to 31 are reserved and set err_o.
- R5: Modifier 1 (PC-low) sets is_pc_o. pc_offset_o is bits [59:0] of the merged constant, sign-extended to 64 bits, whichever half is selected.
- R6: Modifier 2 (PC-high) with the high half selected sets is_pc_o. pc_offset_o is bits [59:32] sign-extended from bit 59. With the low half selected, is_pc_o is 0 and operand_o is the raw low word.
- R7: Modifier 3 (PC-low/high) sets is_pc_o. pc_offset_o is the selected 32-bit half with its bits [27:0] sign-extended from bit 27.
- R8: With is_pc_o set, pc_target_o is clause_idx_i plus pc_offset_o divided by 16. A nonzero pc_offset_o[3:0] sets err_o. A zero offset sets self_loop_o.
- R9: Modifier-field decode, codes 0 none, 1 lo, 2 hi, 3 lohi: m1_i of 8 or more gives (none, none). m1_i rows 0..6 give (none,none), (lo,none), (lo,lo), -, (hi,none), (hi,hi), (lo,none). m1_i = 7 uses m2_i rows 0..3: (lohi,none), (lohi,hi), (lohi,lohi), (lohi,hi).
- R10: m1_i = 3, or m1_i = 7 with m2_i of 4 or more, sets mod_err_o and gives (none, none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fau_idx_i | input | 8 | Operand source index |
| hi_half_i | input | 1 | Select the high 32-bit half |
| clause_idx_i | input | CLAUSE_W | Index of the current clause |
| const_i | input | NUM_CONST*CONST_W | Embedded constants, slot s at bits [s*64 +: 64] |
| const_mod_i | input | NUM_CONST*2 | Modifier code per slot, slot s at bits [s*2 +: 2] |
| m1_i | input | 4 | First modifier field |
| m2_i | input | 4 | Second modifier field |
| kind_o | output | 2 | 0 uniform, 1 constant, 2 special |
| sel_o | output | 7 | Uniform number, constant slot or special code |
| word_hi_o | output | 1 | Registered half-select flag |
| operand_o | output | CONST_W/2 | Selected half of the merged constant |
| is_pc_o | output | 1 | Offset and target are valid |
| pc_offset_o | output | CONST_W | Sign-extended byte offset |
| pc_target_o | output | CLAUSE_W | Target clause index |
| self_loop_o | output | 1 | PC-relative offset is zero |
| err_o | output | 1 | Reserved index or misaligned offset |
| mod0_o | output | 2 | Decoded modifier, first constant |
| mod1_o | output | 2 | Decoded modifier, second constant |
| mod_err_o | output | 1 | Illegal modifier field combination |

## Verification
Every output has one cycle of latency: operand, offset, target, flags and decoded modifiers all come from inputs captured at the preceding rising edge. The bench changes inputs on the falling edge, waits for one rising edge, and samples at the next falling edge, so each check sees exactly one registered update. The bound assertions also compare outputs against inputs delayed by one cycle. They are held off until one clock has passed since reset, so no pre-reset value is ever compared.

// File: rtl/fau_res_pkg.sv
package fau_res_pkg;
  typedef enum logic [1:0] {
    KIND_UNI   = 2'd0,
    KIND_CONST = 2'd1,
    KIND_SPEC  = 2'd2
  } src_kind_e;

  typedef enum logic [1:0] {
    CMOD_NONE    = 2'd0,
    CMOD_PC_LO   = 2'd1,
    CMOD_PC_HI   = 2'd2,
    CMOD_PC_LOHI = 2'd3
  } cmod_e;

  localparam int unsigned IDX_W = 8;
  localparam int unsigned SLOT_W = 3;
endpackage

// File: rtl/fau_idx_decode.sv
module fau_idx_decode import fau_res_pkg::*; (
  input  logic [IDX_W-1:0]  idx_i,
  output src_kind_e         kind_o,
  output logic [6:0]        sel_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              reserved_o
);
  logic [2:0] nib;
  assign nib = idx_i[6:4];

  always_comb begin
    kind_o     = KIND_SPEC;
    sel_o      = idx_i[6:0];
    slot_o     = '0;
    reserved_o = 1'b0;
    if (idx_i[7]) begin
      kind_o = KIND_UNI;
    end else if (nib >= 3'd2) begin
      kind_o = KIND_CONST;
      // scrambled slot map: 2,3 -> 4,5 ; 4..7 -> 0..3
      slot_o = (nib < 3'd4) ? SLOT_W'(nib + 3'd2) : SLOT_W'(nib - 3'd4);
      sel_o  = {4'd0, slot_o};
    end else begin
      reserved_o = (idx_i[4] == 1'b1) || (idx_i[3:0] == 4'd7);
    end
  end
endmodule

// File: rtl/fau_mod_decode.sv
module fau_mod_decode import fau_res_pkg::*; (
  input  logic [3:0] m1_i,
  input  logic [3:0] m2_i,
  output cmod_e      mod0_o,
  output cmod_e      mod1_o,
  output logic       err_o
);
  always_comb begin
    mod0_o = CMOD_NONE;
    mod1_o = CMOD_NONE;
    err_o  = 1'b0;
    if (!m1_i[3]) begin
      unique case (m1_i[2:0])
        3'd0: ;
        3'd1: mod0_o = CMOD_PC_LO;
        3'd2: begin mod0_o = CMOD_PC_LO; mod1_o = CMOD_PC_LO; end
        3'd3: err_o = 1'b1;
        3'd4: mod0_o = CMOD_PC_HI;
        3'd5: begin mod0_o = CMOD_PC_HI; mod1_o = CMOD_PC_HI; end
        3'd6: mod0_o = CMOD_PC_LO;
        3'd7: begin
          if (m2_i >= 4'd4) begin
            err_o = 1'b1;
          end else begin
            mod0_o = CMOD_PC_LOHI;
            unique case (m2_i[1:0])
              2'd0: mod1_o = CMOD_NONE;
              2'd2: mod1_o = CMOD_PC_LOHI;
              default: mod1_o = CMOD_PC_HI;
            endcase
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fau_pc_resolve.sv
module fau_pc_resolve import fau_res_pkg::*; #(
  parameter int unsigned CONST_W  = 64,
  parameter int unsigned CLAUSE_W = 32
) (
  input  logic [CONST_W-1:0]  imm_i,
  input  cmod_e               mod_i,
  input  logic                hi_i,
  input  logic [CLAUSE_W-1:0] clause_i,
  output logic                is_pc_o,
  output logic [CONST_W-1:0]  offset_o,
  output logic [CLAUSE_W-1:0] target_o,
  output logic                misalign_o,
  output logic                zero_o
);
  localparam int unsigned HALF_W = CONST_W / 2;
  localparam int unsigned PAD_W  = CONST_W - HALF_W + 4;

  logic [CONST_W-1:0] sx_long, sx_lo, sx_hi, step;

  assign sx_long = {{4{imm_i[CONST_W-5]}}, imm_i[CONST_W-5:0]};
  assign sx_lo   = {{PAD_W{imm_i[HALF_W-5]}}, imm_i[HALF_W-5:0]};
  assign sx_hi   = {{PAD_W{imm_i[CONST_W-5]}}, imm_i[CONST_W-5:HALF_W]};

  always_comb begin
    is_pc_o  = 1'b0;
    offset_o = '0;
    unique case (mod_i)
      CMOD_PC_LO:   begin is_pc_o = 1'b1; offset_o = sx_long; end
      CMOD_PC_HI:   begin is_pc_o = hi_i; offset_o = hi_i ? sx_hi : '0; end
      CMOD_PC_LOHI: begin is_pc_o = 1'b1; offset_o = hi_i ? sx_hi : sx_lo; end
      default: ;
    endcase
  end

  // offset in bytes, clauses are 16 bytes
  assign step       = $signed(offset_o) >>> 4;
  assign target_o   = clause_i + step[CLAUSE_W-1:0];
  assign misalign_o = is_pc_o && (offset_o[3:0] != 4'd0);
  assign zero_o     = is_pc_o && (offset_o == '0);
endmodule

// File: rtl/fau_operand_resolver.sv
module fau_operand_resolver import fau_res_pkg::*; #(
  parameter int unsigned CLAUSE_W  = 32,
  parameter int unsigned CONST_W   = 64,
  parameter int unsigned NUM_CONST = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [7:0]                    fau_idx_i,
  input  logic                          hi_half_i,
  input  logic [CLAUSE_W-1:0]           clause_idx_i,
  input  logic [NUM_CONST*CONST_W-1:0]  const_i,
  input  logic [NUM_CONST*2-1:0]        const_mod_i,
  input  logic [3:0]                    m1_i,
  input  logic [3:0]                    m2_i,
  output logic [1:0]                    kind_o,
  output logic [6:0]                    sel_o,
  output logic                          word_hi_o,
  output logic [CONST_W/2-1:0]          operand_o,
  output logic                          is_pc_o,
  output logic [CONST_W-1:0]            pc_offset_o,
  output logic [CLAUSE_W-1:0]           pc_target_o,
  output logic                          self_loop_o,
  output logic                          err_o,
  output logic [1:0]                    mod0_o,
  output logic [1:0]                    mod1_o,
  output logic                          mod_err_o
);
  localparam int unsigned HALF_W = CONST_W / 2;

  logic [CONST_W-1:0] const_arr [NUM_CONST];
  cmod_e              mod_arr   [NUM_CONST];

  for (genvar s = 0; s < NUM_CONST; s++) begin : g_unpack
    assign const_arr[s] = const_i[s*CONST_W +: CONST_W];
    assign mod_arr[s]   = cmod_e'(const_mod_i[s*2 +: 2]);
  end

  src_kind_e         kind_d;
  logic [6:0]        sel_d;
  logic [SLOT_W-1:0] slot;
  logic              reserved;

  fau_idx_decode u_idx (
    .idx_i      (fau_idx_i),
    .kind_o     (kind_d),
    .sel_o      (sel_d),
    .slot_o     (slot),
    .reserved_o (reserved)
  );

  logic [CONST_W-1:0] imm;
  cmod_e              mod_sel;
  logic [HALF_W-1:0]  operand_d;

  always_comb begin
    imm       = '0;
    mod_sel   = CMOD_NONE;
    operand_d = '0;
    if (kind_d == KIND_CONST && int'(slot) < NUM_CONST) begin
      imm       = const_arr[slot] | CONST_W'(fau_idx_i[3:0]);
      mod_sel   = mod_arr[slot];
      operand_d = hi_half_i ? imm[CONST_W-1:HALF_W] : imm[HALF_W-1:0];
    end
  end

  logic                is_pc_d, misalign, zero_off;
  logic [CONST_W-1:0]  offset_d;
  logic [CLAUSE_W-1:0] target_d;

  fau_pc_resolve #(.CONST_W(CONST_W), .CLAUSE_W(CLAUSE_W)) u_pc (
    .imm_i      (imm),
    .mod_i      (mod_sel),
    .hi_i       (hi_half_i),
    .clause_i   (clause_idx_i),
    .is_pc_o    (is_pc_d),
    .offset_o   (offset_d),
    .target_o   (target_d),
    .misalign_o (misalign),
    .zero_o     (zero_off)
  );

  cmod_e m0_d, m1_d;
  logic  merr_d;

  fau_mod_decode u_mod (
    .m1_i   (m1_i),
    .m2_i   (m2_i),
    .mod0_o (m0_d),
    .mod1_o (m1_d),
    .err_o  (merr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o      <= '0;
      sel_o       <= '0;
      word_hi_o   <= 1'b0;
      operand_o   <= '0;
      is_pc_o     <= 1'b0;
      pc_offset_o <= '0;
      pc_target_o <= '0;
      self_loop_o <= 1'b0;
      err_o       <= 1'b0;
      mod0_o      <= '0;
      mod1_o      <= '0;
      mod_err_o   <= 1'b0;
    end else begin
      kind_o      <= kind_d;
      sel_o       <= sel_d;
      word_hi_o   <= hi_half_i;
      operand_o   <= operand_d;
      is_pc_o     <= is_pc_d;
      pc_offset_o <= offset_d;
      pc_target_o <= is_pc_d ? target_d : '0;
      self_loop_o <= zero_off;
      err_o       <= reserved | misalign;
      mod0_o      <= m0_d;
      mod1_o      <= m1_d;
      mod_err_o   <= merr_d;
    end
  end
endmodule

// File: rtl/fau_operand_resolver_chk.sv
module fau_operand_resolver_chk #(
  parameter int unsigned CLAUSE_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          fau_idx_i,
  input logic                hi_half_i,
  input logic [CLAUSE_W-1:0] clause_idx_i,
  input logic [3:0]          m1_i,
  input logic [1:0]          kind_o,
  input logic [6:0]          sel_o,
  input logic                word_hi_o,
  input logic                is_pc_o,
  input logic [CLAUSE_W-1:0] pc_target_o,
  input logic                self_loop_o,
  input logic                err_o,
  input logic [1:0]          mod0_o,
  input logic [1:0]          mod1_o,
  input logic                mod_err_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  a_r2_uniform_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(fau_idx_i[7]) |->
      kind_o == 2'd0 && sel_o == $past(fau_idx_i[6:0]) && word_hi_o == $past(hi_half_i) && !err_o);

  a_r4_reserved_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(fau_idx_i < 8'h20 && (fau_idx_i == 8'h07 || fau_idx_i >= 8'h10)) |-> err_o);

  a_r8_self_loop_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && self_loop_o |-> is_pc_o && pc_target_o == $past(clause_idx_i));

  a_r9_m1_high_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(m1_i[3]) |-> mod0_o == 2'd0 && mod1_o == 2'd0 && !mod_err_o);

  a_r10_m1_three_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(m1_i == 4'd3) |-> mod_err_o && mod0_o == 2'd0);
endmodule

bind fau_operand_resolver fau_operand_resolver_chk #(.CLAUSE_W(CLAUSE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fau_idx_i    (fau_idx_i),
  .hi_half_i    (hi_half_i),
  .clause_idx_i (clause_idx_i),
  .m1_i         (m1_i),
  .kind_o       (kind_o),
  .sel_o        (sel_o),
  .word_hi_o    (word_hi_o),
  .is_pc_o      (is_pc_o),
  .pc_target_o  (pc_target_o),
  .self_loop_o  (self_loop_o),
  .err_o        (err_o),
  .mod0_o       (mod0_o),
  .mod1_o       (mod1_o),
  .mod_err_o    (mod_err_o)
);

// File: tb/sim_fau_operand_resolver.sv
`timescale 1ns/1ps
module sim_fau_operand_resolver;
  localparam int CW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    fau_idx_i = '0;
  logic          hi_half_i = 1'b0;
  logic [CW-1:0] clause_idx_i = '0;
  logic [383:0]  const_i = '0;
  logic [11:0]   const_mod_i = '0;
  logic [3:0]    m1_i = '0, m2_i = '0;
  logic [1:0]    kind_o, mod0_o, mod1_o;
  logic [6:0]    sel_o;
  logic          word_hi_o, is_pc_o, self_loop_o, err_o, mod_err_o;
  logic [31:0]   operand_o;
  logic [63:0]   pc_offset_o;
  logic [CW-1:0] pc_target_o;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  fau_operand_resolver #(.CLAUSE_W(CW)) u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] idx, logic hi, logic [CW-1:0] cl);
    @(negedge clk_i);
    fau_idx_i = idx; hi_half_i = hi; clause_idx_i = cl;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic set_slot(int s, logic [63:0] v, logic [1:0] m);
    const_i[s*64 +: 64] = v;
    const_mod_i[s*2 +: 2] = m;
  endtask

  task automatic t_reset;
    chk("R1 kind", kind_o, 0); chk("R1 operand", operand_o, 0);
    chk("R1 err", err_o, 0); chk("R1 offset", pc_offset_o, 0);
    chk("R1 modsel", {mod0_o, mod1_o, mod_err_o}, 0);
  endtask

  task automatic t_uniform;
    apply(8'h85, 1'b1, 0);
    chk("R2 kind", kind_o, 0); chk("R2 sel", sel_o, 7'h05);
    chk("R2 word", word_hi_o, 1); chk("R2 err", err_o, 0);
    apply(8'hFF, 1'b0, 0);
    chk("R2 sel max", sel_o, 7'h7F); chk("R2 word lo", word_hi_o, 0);
  endtask

  task automatic t_const;
    set_slot(4, 64'h1111_2222_3333_4440, 2'd0);
    set_slot(0, 64'hAAAA_BBBB_CCCC_DDD0, 2'd0);
    apply(8'h2A, 1'b0, 0);
    chk("R3 kind", kind_o, 1); chk("R3 slot 2->4", sel_o, 4);
    chk("R3 lo merge", operand_o, 32'h3333_444A); chk("R3 not pc", is_pc_o, 0);
    apply(8'h2A, 1'b1, 0);
    chk("R3 hi half", operand_o, 32'h1111_2222);
    apply(8'h45, 1'b0, 0);
    chk("R3 slot 4->0", sel_o, 0); chk("R3 slot0 val", operand_o, 32'hCCCC_DDD5);
    apply(8'h3F, 1'b0, 0); chk("R3 slot 3->5", sel_o, 5);
    apply(8'h7F, 1'b0, 0); chk("R3 slot 7->3", sel_o, 3);
  endtask

  task automatic t_special;
    apply(8'h03, 1'b0, 0);
    chk("R4 kind", kind_o, 2); chk("R4 sel", sel_o, 3); chk("R4 ok", err_o, 0);
    apply(8'h0C, 1'b1, 0); chk("R4 blend ok", err_o, 0);
    apply(8'h07, 1'b0, 0); chk("R4 rsv 7", err_o, 1);
    apply(8'h13, 1'b0, 0); chk("R4 rsv 0x13", err_o, 1);
    apply(8'h1F, 1'b0, 0); chk("R4 rsv 0x1F", err_o, 1);
    apply(8'h00, 1'b0, 0); chk("R4 zero ok", err_o, 0);
  endtask

  task automatic t_pc_lo;
    set_slot(0, 64'h0FFF_FFFF_FFFF_FFE0, 2'd1);
    apply(8'h40, 1'b0, 10);
    chk("R5 is_pc", is_pc_o, 1); chk("R5 offset", pc_offset_o, 64'hFFFF_FFFF_FFFF_FFE0);
    chk("R8 target", pc_target_o, 8); chk("R8 no err", err_o, 0);
    apply(8'h40, 1'b1, 10);
    chk("R5 hi same offset", pc_offset_o, 64'hFFFF_FFFF_FFFF_FFE0);
  endtask

  task automatic t_pc_hi;
    set_slot(1, 64'hF000_0100_1234_5670, 2'd2);
    apply(8'h50, 1'b1, 5);
    chk("R6 is_pc", is_pc_o, 1); chk("R6 offset", pc_offset_o, 64'h100);
    chk("R8 target fwd", pc_target_o, 21);
    apply(8'h50, 1'b0, 5);
    chk("R6 lo not pc", is_pc_o, 0); chk("R6 lo raw", operand_o, 32'h1234_5670);
  endtask

  task automatic t_pc_lohi;
    set_slot(2, 64'h0000_0030_FFFF_FFF0, 2'd3);
    apply(8'h60, 1'b0, 3);
    chk("R7 lo offset", pc_offset_o, 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R7 lo target", pc_target_o, 2);
    apply(8'h60, 1'b1, 3);
    chk("R7 hi offset", pc_offset_o, 64'h30); chk("R7 hi target", pc_target_o, 6);
  endtask

  task automatic t_loop_align;
    set_slot(3, 64'h0, 2'd1);
    apply(8'h70, 1'b0, 9);
    chk("R8 self loop", self_loop_o, 1); chk("R8 loop target", pc_target_o, 9);
    chk("R8 loop err", err_o, 0);
    apply(8'h71, 1'b0, 9);
    chk("R8 misalign err", err_o, 1); chk("R8 misalign no loop", self_loop_o, 0);
  endtask

  function automatic logic [4:0] exp_mod(logic [3:0] a, logic [3:0] b);
    // {err, mod0, mod1}; 0 none 1 lo 2 hi 3 lohi
    if (a >= 8) return 5'b0_00_00;
    case (a)
      0: return 5'b0_00_00; 1: return 5'b0_01_00; 2: return 5'b0_01_01;
      3: return 5'b1_00_00; 4: return 5'b0_10_00; 5: return 5'b0_10_10;
      6: return 5'b0_01_00;
      default: case (b)
        0: return 5'b0_11_00; 1: return 5'b0_11_10;
        2: return 5'b0_11_11; 3: return 5'b0_11_10;
        default: return 5'b1_00_00;
      endcase
    endcase
  endfunction

  task automatic t_mods;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk_i); m1_i = 4'(a); m2_i = 0;
      @(posedge clk_i); @(negedge clk_i);
      chk(a == 3 ? "R10 m1=3" : "R9 m1 row", {mod_err_o, mod0_o, mod1_o}, exp_mod(4'(a), 0));
    end
    for (int b = 0; b < 16; b++) begin
      @(negedge clk_i); m1_i = 7; m2_i = 4'(b);
      @(posedge clk_i); @(negedge clk_i);
      chk(b >= 4 ? "R10 m2 bad" : "R9 m2 row", {mod_err_o, mod0_o, mod1_o}, exp_mod(7, 4'(b)));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_uniform(); t_const(); t_special();
        t_pc_lo(); t_pc_hi(); t_pc_lohi(); t_loop_align(); t_mods();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule